// File: doc/BRIEF.md
# Charger fault supervisor

This block sits beside a switch-mode battery charger and turns a handful of digital event inputs into latched faults and a shutdown request. The inputs are a per-switching-cycle inductor peak-limit indication, a battery-below-short-threshold comparator, a charge-active flag, and three die-temperature comparators. The temperature comparators report the 130 °C warning, the 140 °C trip, and being below the 110 °C release point.

The block keeps a 4-bit sticky fault register. The host clears a bit by writing a 1 to it. A live peak-current status bit follows the current run of limited cycles. The shutdown request combines two sources. One is a hysteretic over-temperature shutdown. The other is an optional shutdown after a run of peak limits, which the host can reduce to a flag only.

The battery short timeout is taken from an eight-entry table of seconds selected by a 3-bit code. Seconds are derived from the clock through a parameterised prescaler.

Top module: `chg_fault_sup`

## Requirements
- R1: After reset, `fault_o` is 0000, `shutdown_req` and `pk_status` are 0, the peak-run mode is flag-only, and the timeout code is 100 (30 s).
- R2: `pk_status` goes to 1 once four consecutive switching ticks (`sw_tick`=1) carry `pk_hit`=1. It returns to 0 on the first tick with `pk_hit`=0, and that tick also restarts the run count from zero.
- R3: A run of four or more limited ticks sets fault bit 2. In flag-only mode (`cfg_pk_flag_only`=1) the run does not raise `shutdown_req`.
- R4: With flag-only mode off, a run of four or more limited ticks raises `shutdown_req`. The request stays high until the host clears fault bit 2.
- R5: With `bat_low`=1 and `chg_active`=1 held, fault bit 3 sets after exactly T×TICKS_PER_SEC clock cycles. T in seconds follows the code: 000=1, 001=2, 010=4, 011=10, 100=30, 101=60, 110=120, 111=180.
- R6: Any cycle in which `bat_low` or `chg_active` is 0 restarts the short timer from zero.
- R7: With `chg_active`=0, a low battery never sets fault bit 3.
- R8: `temp_warn`=1 sets fault bit 1 and does not raise `shutdown_req`.
- R9: `temp_crit`=1 sets fault bit 0 and raises `shutdown_req`. The over-temperature request is released only in a cycle where `temp_cool`=1 and `temp_crit`=0.
- R10: A fault bit stays at 1 after its cause is gone. A write with `clr_we`=1 clears exactly the bits set in `clr_mask`.
- R11: When a clear and a new event for the same bit fall in the same cycle, the bit ends up at 1.
- R12: `pk_hit` has no effect in a cycle without `sw_tick`. The run count neither advances nor resets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_tick | input | 1 | One-cycle pulse marking the end of a switching cycle |
| pk_hit | input | 1 | The switching cycle ending now reached the peak limit |
| bat_low | input | 1 | Battery is below the short threshold |
| chg_active | input | 1 | Charging is in progress |
| temp_warn | input | 1 | Die is above 130 °C |
| temp_crit | input | 1 | Die is above 140 °C |
| temp_cool | input | 1 | Die is below 110 °C |
| cfg_we | input | 1 | Load the two configuration fields |
| cfg_pk_flag_only | input | 1 | 1: a peak run only flags; 0: it also requests shutdown |
| cfg_short_sel | input | 3 | Battery short timeout code |
| clr_we | input | 1 | Write strobe for clearing fault bits |
| clr_mask | input | 4 | Bits to clear (1 clears) |
| shutdown_req | output | 1 | Registered shutdown request |
| pk_status | output | 1 | Live status: current run of limited ticks has reached four |
| fault_o | output | 4 | Sticky faults: [3] battery short, [2] peak run, [1] 130 °C, [0] 140 °C |

## Verification
On every cycle, the assertions check several properties. Each fault bit survives unless it is masked for clearing. A new warning or trip always lands in the register, even against a clear. A rise of `pk_status` or `shutdown_req` has a legal cause in the cycle before. A drop of the request is preceded by a cool indication or a peak-bit clear. Properties cannot show the counted behaviours: the exact cycle at which each of the eight timeouts expires, the timer restart after a one-cycle gap, and how the run count treats a miss versus a missing tick. The bench covers these with directed scenarios and a stimulus table.

// File: rtl/chg_fault_pkg.sv
package chg_fault_pkg;
  localparam int FLT_W    = 4;
  localparam int FB_SHORT = 3;
  localparam int FB_PEAK  = 2;
  localparam int FB_WARN  = 1;
  localparam int FB_CRIT  = 0;
  localparam int SEL_W    = 3;
  localparam int SEC_W    = 8;

  // Timeout in seconds for each short-timer code.
  function automatic logic [SEC_W-1:0] short_secs(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd0:    short_secs = 8'd1;
      3'd1:    short_secs = 8'd2;
      3'd2:    short_secs = 8'd4;
      3'd3:    short_secs = 8'd10;
      3'd4:    short_secs = 8'd30;
      3'd5:    short_secs = 8'd60;
      3'd6:    short_secs = 8'd120;
      default: short_secs = 8'd180;
    endcase
  endfunction
endpackage

// File: rtl/pk_run_mon.sv
module pk_run_mon #(
  parameter int RUN_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic hit,
  output logic run_trip,
  output logic run_status
);
  localparam int CNT_W = $clog2(RUN_LEN + 1);
  localparam logic [CNT_W-1:0] RUN_MAX = CNT_W'(RUN_LEN);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             status_q;

  always_comb begin
    cnt_d = cnt_q;
    if (tick) begin
      if (!hit)                cnt_d = '0;
      else if (cnt_q != RUN_MAX) cnt_d = cnt_q + 1'b1;
    end
  end

  assign run_trip   = tick && hit && (cnt_d == RUN_MAX);
  assign run_status = status_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      status_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (tick) status_q <= (cnt_d == RUN_MAX);
    end
  end
endmodule

// File: rtl/bat_short_timer.sv
module bat_short_timer
  import chg_fault_pkg::*;
#(
  parameter int TICKS_PER_SEC = 50_000_000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             armed,
  input  logic [SEL_W-1:0] sel,
  output logic             expire
);
  localparam int PRE_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICKS_PER_SEC - 1);

  logic [PRE_W-1:0] pre_q;
  logic [SEC_W-1:0] sec_q;
  logic [SEC_W-1:0] limit;
  logic             done;
  logic             sec_wrap;

  assign limit    = short_secs(sel);
  assign done     = (sec_q >= limit);
  assign sec_wrap = (pre_q == PRE_LAST);
  assign expire   = armed && !done && sec_wrap && ((sec_q + 1'b1) == limit);

  always_ff @(posedge clk) begin
    if (rst || !armed) begin
      pre_q <= '0;
      sec_q <= '0;
    end else if (!done) begin
      if (sec_wrap) begin
        pre_q <= '0;
        sec_q <= sec_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ot_monitor.sv
module ot_monitor (
  input  logic clk,
  input  logic rst,
  input  logic hot,
  input  logic cool,
  output logic ot_next,
  output logic ot_state
);
  always_comb begin
    ot_next = ot_state;
    if (hot)       ot_next = 1'b1;
    else if (cool) ot_next = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) ot_state <= 1'b0;
    else     ot_state <= ot_next;
  end
endmodule

// File: rtl/chg_fault_sup.sv
module chg_fault_sup
  import chg_fault_pkg::*;
#(
  parameter int RUN_LEN       = 4,
  parameter int TICKS_PER_SEC = 50_000_000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sw_tick,
  input  logic             pk_hit,
  input  logic             bat_low,
  input  logic             chg_active,
  input  logic             temp_warn,
  input  logic             temp_crit,
  input  logic             temp_cool,
  input  logic             cfg_we,
  input  logic             cfg_pk_flag_only,
  input  logic [SEL_W-1:0] cfg_short_sel,
  input  logic             clr_we,
  input  logic [FLT_W-1:0] clr_mask,
  output logic             shutdown_req,
  output logic             pk_status,
  output logic [FLT_W-1:0] fault_o
);
  logic             flag_only_q;
  logic [SEL_W-1:0] short_sel_q;
  logic             run_trip;
  logic             short_expire;
  logic             ot_next, ot_state;
  logic             pk_sd_q, pk_sd_d;
  logic [FLT_W-1:0] set_vec, clr_vec, fault_q;
  logic             sd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_only_q <= 1'b1;
      short_sel_q <= 3'b100;
    end else if (cfg_we) begin
      flag_only_q <= cfg_pk_flag_only;
      short_sel_q <= cfg_short_sel;
    end
  end

  pk_run_mon #(.RUN_LEN(RUN_LEN)) u_run (
    .clk(clk), .rst(rst), .tick(sw_tick), .hit(pk_hit),
    .run_trip(run_trip), .run_status(pk_status)
  );

  bat_short_timer #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_short (
    .clk(clk), .rst(rst), .armed(bat_low && chg_active),
    .sel(short_sel_q), .expire(short_expire)
  );

  ot_monitor u_ot (
    .clk(clk), .rst(rst), .hot(temp_crit), .cool(temp_cool),
    .ot_next(ot_next), .ot_state(ot_state)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[FB_SHORT] = short_expire;
    set_vec[FB_PEAK]  = run_trip;
    set_vec[FB_WARN]  = temp_warn;
    set_vec[FB_CRIT]  = temp_crit;
    clr_vec           = clr_we ? clr_mask : '0;
  end

  always_comb begin
    pk_sd_d = pk_sd_q;
    if (run_trip && !flag_only_q) pk_sd_d = 1'b1;
    else if (clr_vec[FB_PEAK])    pk_sd_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_q <= '0;
      pk_sd_q <= 1'b0;
      sd_q    <= 1'b0;
    end else begin
      fault_q <= (fault_q & ~clr_vec) | set_vec;
      pk_sd_q <= pk_sd_d;
      sd_q    <= pk_sd_d | ot_next;
    end
  end

  assign fault_o      = fault_q;
  assign shutdown_req = sd_q;
endmodule

// File: rtl/chg_fault_sva.sv
module chg_fault_sva (
  input logic       clk,
  input logic       rst,
  input logic       sw_tick,
  input logic       pk_hit,
  input logic       bat_low,
  input logic       chg_active,
  input logic       temp_warn,
  input logic       temp_crit,
  input logic       temp_cool,
  input logic       clr_we,
  input logic [3:0] clr_mask,
  input logic       flag_only,
  input logic       shutdown_req,
  input logic       pk_status,
  input logic [3:0] fault_o
);
  logic [3:0] keep;
  assign keep = fault_o & ~(clr_we ? clr_mask : 4'b0000);

  assert_status_cause_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(pk_status) |-> $past(sw_tick && pk_hit));

  assert_sd_cause_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(shutdown_req) |-> ($past(temp_crit) || ($past(sw_tick && pk_hit) && !$past(flag_only))));

  assert_short_cause_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_o[3]) |-> $past(bat_low && chg_active));

  assert_warn_latch_R8: assert property (@(posedge clk) disable iff (rst)
    temp_warn |=> fault_o[1]);

  assert_crit_trip_R9: assert property (@(posedge clk) disable iff (rst)
    temp_crit |=> (fault_o[0] && shutdown_req));

  assert_release_cause_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(shutdown_req) |-> $past(temp_cool || (clr_we && clr_mask[2])));

  assert_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (keep != 4'b0000) |=> ((fault_o & $past(keep)) == $past(keep)));

  assert_set_wins_R11: assert property (@(posedge clk) disable iff (rst)
    (temp_crit && clr_we && clr_mask[0]) |=> fault_o[0]);
endmodule

bind chg_fault_sup chg_fault_sva u_sva (
  .clk(clk), .rst(rst), .sw_tick(sw_tick), .pk_hit(pk_hit),
  .bat_low(bat_low), .chg_active(chg_active), .temp_warn(temp_warn),
  .temp_crit(temp_crit), .temp_cool(temp_cool), .clr_we(clr_we),
  .clr_mask(clr_mask), .flag_only(flag_only_q), .shutdown_req(shutdown_req),
  .pk_status(pk_status), .fault_o(fault_o)
);

// File: tb/tb_chg_fault_sup.sv
module tb_chg_fault_sup;
  localparam int TPS = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sw_tick = 0, pk_hit = 0, bat_low = 0, chg_active = 0;
  logic       temp_warn = 0, temp_crit = 0, temp_cool = 0;
  logic       cfg_we = 0, cfg_pk_flag_only = 1;
  logic [2:0] cfg_short_sel = 3'b100;
  logic       clr_we = 0;
  logic [3:0] clr_mask = 0;
  logic       shutdown_req, pk_status;
  logic [3:0] fault_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  chg_fault_sup #(.RUN_LEN(4), .TICKS_PER_SEC(TPS)) dut (
    .clk(clk), .rst(rst), .sw_tick(sw_tick), .pk_hit(pk_hit),
    .bat_low(bat_low), .chg_active(chg_active), .temp_warn(temp_warn),
    .temp_crit(temp_crit), .temp_cool(temp_cool), .cfg_we(cfg_we),
    .cfg_pk_flag_only(cfg_pk_flag_only), .cfg_short_sel(cfg_short_sel),
    .clr_we(clr_we), .clr_mask(clr_mask), .shutdown_req(shutdown_req),
    .pk_status(pk_status), .fault_o(fault_o)
  );

  // {sw_tick, pk_hit, expected pk_status}
  localparam logic [2:0] PK_VEC [12] = '{
    3'b110, 3'b110, 3'b110, 3'b111, 3'b111, 3'b100,
    3'b110, 3'b110, 3'b110, 3'b010, 3'b111, 3'b100
  };

  function automatic int secs_of(input logic [2:0] s);
    case (s)
      3'd0: secs_of = 1;   3'd1: secs_of = 2;   3'd2: secs_of = 4;
      3'd3: secs_of = 10;  3'd4: secs_of = 30;  3'd5: secs_of = 60;
      3'd6: secs_of = 120; default: secs_of = 180;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pk_step(input logic t, input logic h);
    sw_tick = t; pk_hit = h;
    @(negedge clk);
    sw_tick = 0; pk_hit = 0;
  endtask

  task automatic clear(input logic [3:0] m);
    clr_we = 1; clr_mask = m;
    @(negedge clk);
    clr_we = 0; clr_mask = 0;
  endtask

  task automatic config_set(input logic fo, input logic [2:0] s);
    cfg_we = 1; cfg_pk_flag_only = fo; cfg_short_sel = s;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic short_run(input int n, input string req);
    bat_low = 1; chg_active = 1;
    repeat (n - 1) @(negedge clk);
    check({req, " before timeout"}, fault_o[3], 1'b0);
    @(negedge clk);
    check({req, " at timeout"}, fault_o[3], 1'b1);
    bat_low = 0; chg_active = 0;
    @(negedge clk);
    clear(4'b1000);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 fault", fault_o, 4'b0000);
    check("R1 shutdown", shutdown_req, 1'b0);
    check("R1 status", pk_status, 1'b0);
    // R1/R5 default code 100 = 30 s
    short_run(30 * TPS, "R1 R5 default 30s");

    // R2/R12 table walk, default flag-only
    foreach (PK_VEC[i]) begin
      pk_step(PK_VEC[i][2], PK_VEC[i][1]);
      check($sformatf("R2 R12 vector %0d", i), pk_status, PK_VEC[i][0]);
    end
    check("R3 peak bit set", fault_o[2], 1'b1);
    check("R3 flag-only no shutdown", shutdown_req, 1'b0);
    clear(4'b0100);
    check("R10 clear peak bit", fault_o, 4'b0000);

    // R4 shutdown enabled
    config_set(1'b0, 3'b000);
    for (int k = 0; k < 4; k++) pk_step(1'b1, 1'b1);
    check("R4 shutdown raised", shutdown_req, 1'b1);
    pk_step(1'b1, 1'b0);
    repeat (3) @(negedge clk);
    check("R4 shutdown held", shutdown_req, 1'b1);
    check("R2 status drops on miss", pk_status, 1'b0);
    clear(4'b1011);
    check("R10 unmasked bit kept", fault_o[2], 1'b1);
    check("R4 held past other clears", shutdown_req, 1'b1);
    clear(4'b0100);
    check("R4 released by clear", shutdown_req, 1'b0);

    // R8 warning
    temp_warn = 1;
    @(negedge clk);
    check("R8 warn bit", fault_o[1], 1'b1);
    check("R8 no shutdown", shutdown_req, 1'b0);
    // R11 clear against active event
    clr_we = 1; clr_mask = 4'b0010;
    @(negedge clk);
    clr_we = 0; clr_mask = 0;
    check("R11 set wins", fault_o[1], 1'b1);
    temp_warn = 0;
    @(negedge clk);
    check("R10 sticky warn", fault_o[1], 1'b1);
    clear(4'b0010);
    check("R10 warn cleared", fault_o[1], 1'b0);

    // R9 over-temperature hysteresis
    temp_crit = 1;
    @(negedge clk);
    temp_crit = 0;
    check("R9 crit bit", fault_o[0], 1'b1);
    check("R9 shutdown", shutdown_req, 1'b1);
    repeat (5) @(negedge clk);
    check("R9 held until cool", shutdown_req, 1'b1);
    temp_crit = 1; temp_cool = 1;
    @(negedge clk);
    check("R9 crit overrides cool", shutdown_req, 1'b1);
    temp_crit = 0;
    @(negedge clk);
    temp_cool = 0;
    check("R9 released", shutdown_req, 1'b0);
    check("R10 crit bit sticky", fault_o[0], 1'b1);
    clear(4'b0001);

    // R5 every timeout code
    for (int s = 0; s < 8; s++) begin
      config_set(1'b1, 3'(s));
      short_run(secs_of(3'(s)) * TPS, $sformatf("R5 code %0d", s));
    end

    // R6 restart after a one-cycle gap (2 s = 8 cycles)
    config_set(1'b1, 3'b001);
    bat_low = 1; chg_active = 1;
    repeat (6) @(negedge clk);
    bat_low = 0;
    @(negedge clk);
    short_run(8, "R6 restart");

    // R7 not charging
    bat_low = 1; chg_active = 0;
    repeat (40) @(negedge clk);
    check("R7 no short without charging", fault_o[3], 1'b0);
    bat_low = 0;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule